// File: doc/BRIEF.md
# System Control Port with Periodic Tick Interrupt

This block is one 32-bit register on a simple memory-mapped bus in a small handheld console. A write stores a control word. Two bits of that word choose the speaker drive, and clearing one bit after it was set shuts the unit down. A read returns the keypad row data together with the display controller status byte.

The block also keeps the console's interrupt state. A slow tick input, one strobe per period of a 32.768 kHz reference, is divided by 128 to raise a 256 Hz periodic interrupt. That interrupt stays raised until software strobes a separate acknowledge line. A fast-interrupt line is raised by an external request and drops when software reads the register.

Top module: `sysctl_port`

## Requirements
- R1: After reset the stored control word is zero, and `irq_tick`, `fiq_pend`, `pwr_off`, `spk_level` and `bus_rdata` are all zero.
- R2: `irq_tick` rises in the cycle after every TICK_DIV-th `tick_stb` strobe (TICK_DIV = 128 by default). `tick_stb` counts only in the cycles where it is high, and the strobe count starts at reset.
- R3: Once raised, `irq_tick` stays high until `tick_ack` is high, and it is low in the cycle after such an acknowledge.
- R4: If a dividing strobe and `tick_ack` fall in the same cycle, `irq_tick` is high in the next cycle.
- R5: `fiq_req` high sets `fiq_pend` in the next cycle. It stays set until a read cycle (`bus_sel`=1, `bus_we`=0), after which it is low.
- R6: If `fiq_req` and a read fall in the same cycle, `fiq_pend` is high in the next cycle.
- R7: `spk_level` is a two-bit signed value taken from control bits 29:28. Code 0 and code 3 give 0 (2'b00), code 1 gives +1 (2'b01), and code 2 gives −1 (2'b11). It follows a write from the cycle after it.
- R8: `pwr_off` is high for exactly the one cycle after a write whose bit 24 is 0 while the stored word's bit 24 is 1. Any other write, and any cycle without a write, leaves it low.
- R9: In the cycle after a read, `bus_rdata` holds `kbd_row` in bits 7:0 and `disp_status` in bits 23:16, with all other bits zero. It keeps that value until the next read.
- R10: Only a cycle with `bus_sel`=1 and `bus_we`=1 changes the control word. A read, or `bus_we` without `bus_sel`, leaves `spk_level` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register selected this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 32 | Control word to store |
| bus_rdata | output | 32 | Registered read data |
| kbd_row | input | 8 | Keypad row data |
| disp_status | input | 8 | Display controller status byte |
| tick_stb | input | 1 | One-cycle strobe per reference clock period |
| tick_ack | input | 1 | Acknowledge strobe for the periodic interrupt |
| fiq_req | input | 1 | Fast-interrupt request pulse |
| irq_tick | output | 1 | Periodic interrupt level |
| fiq_pend | output | 1 | Pending fast-interrupt level |
| spk_level | output | 2 | Signed speaker drive (+1, 0, −1) |
| pwr_off | output | 1 | One-cycle power-off pulse |

## Verification
Two pairs of events can land in the same cycle: the dividing tick with the acknowledge strobe, and the fast-interrupt request with the clearing read. The directed part of the bench lines up each pair on purpose. In both cases it expects the setting event to win. The random part keeps all inputs active, so both pairs also meet by chance. A reference model in the bench judges every cycle.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned KEY_W    = 8;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned SPK_LSB  = 28;
  localparam int unsigned PWR_BIT  = 24;
  localparam int unsigned STAT_LSB = 16;

  typedef logic signed [1:0] spk_lvl_t;
  localparam spk_lvl_t SPK_ZERO = 2'sb00;
  localparam spk_lvl_t SPK_POS  = 2'sb01;
  localparam spk_lvl_t SPK_NEG  = 2'sb11;
endpackage

// File: rtl/sysctl_tick.sv
module sysctl_tick #(
  parameter int unsigned TICK_DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_stb,
  input  logic tick_ack,
  output logic irq_o
);
  localparam int unsigned CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d;
  logic             fire;

  always_comb begin
    fire  = tick_stb && (cnt_q == CNT_LAST);
    cnt_d = cnt_q;
    if (tick_stb) cnt_d = fire ? '0 : cnt_q + 1'b1;
    irq_d = fire | (irq_q & ~tick_ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (tick_stb) cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

  assert_tick_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> irq_q);
  assert_irq_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_q) |-> $past(tick_ack));
  assert_tick_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && tick_ack) |=> irq_q);
endmodule

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output spk_lvl_t          spk_o,
  output logic              pwr_off_o
);
  logic [WORD_W-1:0] ctrl_q, ctrl_d;
  logic              pwr_q, pwr_d;

  always_comb begin
    ctrl_d = wr_en ? wdata : ctrl_q;
    pwr_d  = wr_en && ctrl_q[PWR_BIT] && !wdata[PWR_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pwr_q  <= 1'b0;
    end else begin
      if (wr_en) ctrl_q <= ctrl_d;
      pwr_q <= pwr_d;
    end
  end

  always_comb begin
    unique case (ctrl_q[SPK_LSB+1:SPK_LSB])
      2'd1:    spk_o = SPK_POS;
      2'd2:    spk_o = SPK_NEG;
      default: spk_o = SPK_ZERO;
    endcase
  end

  assign pwr_off_o = pwr_q;

  assert_pwr_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_q |-> ($past(wr_en) && !ctrl_q[PWR_BIT]));
  assert_pwr_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_q |=> !pwr_q);
  assert_ctrl_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/sysctl_rdpath.sv
module sysctl_rdpath
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              fiq_req,
  input  logic [KEY_W-1:0]  kbd_row,
  input  logic [STAT_W-1:0] disp_status,
  output logic [WORD_W-1:0] rdata_o,
  output logic              fiq_o
);
  logic [WORD_W-1:0] rd_q, rd_d;
  logic              fiq_q, fiq_d;

  always_comb begin
    rd_d = '0;
    rd_d[KEY_W-1:0] = kbd_row;
    rd_d[STAT_LSB +: STAT_W] = disp_status;
    fiq_d = fiq_req | (fiq_q & ~rd_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      fiq_q <= 1'b0;
    end else begin
      if (rd_en) rd_q <= rd_d;
      fiq_q <= fiq_d;
    end
  end

  assign rdata_o = rd_q;
  assign fiq_o   = fiq_q;

  assert_fiq_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !fiq_req) |=> !fiq_q);
  assert_fiq_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_req |=> fiq_q);
  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_q));
endmodule

// File: rtl/sysctl_port.sv
module sysctl_port
  import sysctl_pkg::*;
#(
  parameter int unsigned TICK_DIV = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [7:0]  kbd_row,
  input  logic [7:0]  disp_status,
  input  logic        tick_stb,
  input  logic        tick_ack,
  input  logic        fiq_req,
  output logic        irq_tick,
  output logic        fiq_pend,
  output logic [1:0]  spk_level,
  output logic        pwr_off
);
  logic     wr_en, rd_en;
  spk_lvl_t spk;

  assign wr_en = bus_sel & bus_we;
  assign rd_en = bus_sel & ~bus_we;

  sysctl_tick #(.TICK_DIV(TICK_DIV)) tick_i (
    .clk(clk), .rst_n(rst_n), .tick_stb(tick_stb), .tick_ack(tick_ack),
    .irq_o(irq_tick)
  );

  sysctl_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(bus_wdata),
    .spk_o(spk), .pwr_off_o(pwr_off)
  );

  sysctl_rdpath rd_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .fiq_req(fiq_req),
    .kbd_row(kbd_row), .disp_status(disp_status),
    .rdata_o(bus_rdata), .fiq_o(fiq_pend)
  );

  assign spk_level = spk;
endmodule

// File: tb/sysctl_port_tb_top.sv
module sysctl_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 0, bus_we = 0, tick_stb = 0, tick_ack = 0, fiq_req = 0;
  logic [31:0] bus_wdata = '0;
  logic [7:0]  kbd_row = '0, disp_status = '0;
  logic [31:0] bus_rdata;
  logic        irq_tick, fiq_pend, pwr_off;
  logic [1:0]  spk_level;

  int checks = 0;
  int errors = 0;

  // reference model state
  int          m_cnt;
  logic        m_irq, m_fiq, m_pwr;
  logic [31:0] m_ctrl, m_rd;

  always #4 clk = ~clk;

  sysctl_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .kbd_row(kbd_row),
    .disp_status(disp_status), .tick_stb(tick_stb), .tick_ack(tick_ack),
    .fiq_req(fiq_req), .irq_tick(irq_tick), .fiq_pend(fiq_pend),
    .spk_level(spk_level), .pwr_off(pwr_off)
  );

  function automatic logic [1:0] exp_spk(input logic [31:0] w);
    case (w[29:28])
      2'd1:    return 2'b01;
      2'd2:    return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_irq = 0; m_fiq = 0; m_pwr = 0; m_ctrl = '0; m_rd = '0;
  endtask

  // advance model by one clock edge using the inputs currently driven
  task automatic model_step();
    logic fire;
    fire  = tick_stb && (m_cnt == 127);
    if (tick_stb) m_cnt = fire ? 0 : m_cnt + 1;
    m_irq = fire | (m_irq & ~tick_ack);
    m_fiq = fiq_req | (m_fiq & ~(bus_sel & ~bus_we));
    m_pwr = 1'b0;
    if (bus_sel && bus_we) begin
      m_pwr  = m_ctrl[24] & ~bus_wdata[24];
      m_ctrl = bus_wdata;
    end
    if (bus_sel && !bus_we) m_rd = {8'h00, disp_status, 8'h00, kbd_row};
  endtask

  // inputs are set by the caller at a negedge; one edge, then compare
  task automatic step();
    model_step();
    @(posedge clk);
    #2;
    check("R3 irq_tick", 32'(irq_tick), 32'(m_irq));
    check("R5 fiq_pend", 32'(fiq_pend), 32'(m_fiq));
    check("R7 spk_level", 32'(spk_level), 32'(exp_spk(m_ctrl)));
    check("R8 pwr_off", 32'(pwr_off), 32'(m_pwr));
    check("R9 bus_rdata", bus_rdata, m_rd);
    @(negedge clk);
    bus_sel = 0; bus_we = 0; tick_stb = 0; tick_ack = 0; fiq_req = 0;
  endtask

  task automatic wr(input logic [31:0] w);
    bus_sel = 1; bus_we = 1; bus_wdata = w; step();
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 irq_tick", 32'(irq_tick), 0);
    check("R1 fiq_pend", 32'(fiq_pend), 0);
    check("R1 pwr_off", 32'(pwr_off), 0);
    check("R1 spk_level", 32'(spk_level), 0);
    check("R1 bus_rdata", bus_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: exactly the 128th strobe raises the interrupt
    for (int i = 0; i < 127; i++) begin tick_stb = 1; step(); end
    check("R2 no irq before 128th", 32'(irq_tick), 0);
    tick_stb = 1; step();
    check("R2 irq after 128th", 32'(irq_tick), 1);
    step(); step();
    check("R3 irq held", 32'(irq_tick), 1);
    tick_ack = 1; step();
    check("R3 irq cleared", 32'(irq_tick), 0);

    // R4: ack coinciding with dividing strobe
    for (int i = 0; i < 127; i++) begin tick_stb = 1; step(); end
    tick_stb = 1; tick_ack = 1; step();
    check("R4 tick wins", 32'(irq_tick), 1);
    tick_ack = 1; step();

    // R5/R6: fast interrupt
    fiq_req = 1; step();
    check("R5 fiq set", 32'(fiq_pend), 1);
    kbd_row = 8'hA5; disp_status = 8'h3C; bus_sel = 1; step();
    check("R5 fiq cleared by read", 32'(fiq_pend), 0);
    check("R9 read layout", bus_rdata, 32'h003C_00A5);
    fiq_req = 1; bus_sel = 1; step();
    check("R6 request wins over read", 32'(fiq_pend), 1);

    // R7: all speaker codes
    for (int c = 0; c < 4; c++) begin
      wr(32'(c) << 28);
      check("R7 speaker code", 32'(spk_level), 32'(exp_spk(32'(c) << 28)));
    end

    // R8: bit 24 sequences
    wr(32'h0100_0000); check("R8 rise no pulse", 32'(pwr_off), 0);
    wr(32'h0100_0000); check("R8 stay high no pulse", 32'(pwr_off), 0);
    wr(32'h0000_0000); check("R8 fall pulse", 32'(pwr_off), 1);
    step();            check("R8 pulse one cycle", 32'(pwr_off), 0);
    wr(32'h0000_0000); check("R8 low to low no pulse", 32'(pwr_off), 0);

    // R10: read and unselected write leave control word alone
    wr(32'h1000_0000);
    bus_sel = 1; step();
    check("R10 read keeps speaker", 32'(spk_level), 32'h1);
    bus_we = 1; bus_wdata = 32'h2000_0000; step();
    check("R10 unselected write ignored", 32'(spk_level), 32'h1);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      tick_stb    = ($urandom_range(1) == 0);
      tick_ack    = ($urandom_range(63) == 0);
      fiq_req     = ($urandom_range(15) == 0);
      bus_sel     = ($urandom_range(3) == 0);
      bus_we      = ($urandom_range(1) == 0);
      bus_wdata   = $urandom();
      kbd_row     = 8'($urandom());
      disp_status = 8'($urandom());
      step();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule